// File: doc/BRIEF.md
# Flash Block Erase and Program Sequencer

This block carries out erase and program commands on a flash array arranged as fixed 64-byte blocks. A host loads a small set of parameter registers through a byte-wide configuration port. The registers are an unlock key, a second key, the target block number, a source pointer into a 256-byte local SRAM, and a pulse-length divider. The host then raises a command strobe that selects erase or program.

Once a command is accepted, the sequencer checks three things: the unlock key, whether the block number is in range, and the protection level that an external protection unit reports for the block. If any check fails, the command is aborted with a fixed failure code and no pulse is issued. If all checks pass, an erase drives one timed erase pulse for the whole block. A program fetches 64 bytes from SRAM and drives one timed program pulse per byte. Each pulse is as long as the divider register holds, counted in cycles. The flash cells sit outside the block: erase sets a block to FFh, and programming can only clear bits.

Top module: `flash_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fl_erase`, `fl_prog` and `sram_rd` are low, and `key1_q`, `key2_q` and `acc_q` read 00h.
- R2: A command whose unlock key is not 3Ah fails and issues no erase or program pulse.
- R3: A command whose block number is `NUM_BLOCKS` or above fails and issues no pulse.
- R4: The block number is presented on `prot_blk` and `prot_lvl` is sampled in the checking cycle. Level 2'b11 aborts the command with no pulse and no flash change. Levels 2'b00, 2'b01 and 2'b10 allow it.
- R5: On any failure, `key1_q` becomes 01h and both `key2_q` and `acc_q` become 00h.
- R6: On success, `key1_q` becomes 00h, `acc_q` takes the block number, and `key2_q` keeps its value.
- R7: An erase (`cmd_op`=0) drives exactly one `fl_erase` pulse. Its length is max(divider,1) cycles, and `fl_addr` holds the block base (low 6 bits zero).
- R8: A program (`cmd_op`=1) drives 64 `fl_prog` pulses, each max(divider,1) cycles long. Pulse k carries `fl_addr` = block*64+k with k rising, and `fl_wdata` = the SRAM byte at (pointer+k) mod 256. `fl_addr` and `fl_wdata` stay steady within a pulse. The resulting flash byte is the old byte ANDed with the data.
- R9: `busy` is high from the cycle after acceptance until the operation ends, lasting:
  - 1 cycle for a failure;
  - 1+max(divider,1) cycles for an erase;
  - 1+64×(max(divider,1)+2) cycles for a program.
  `done` pulses high for one cycle, the first cycle with `busy` low.
- R10: While `busy` is high, command strobes and configuration writes are ignored.
- R11: Configuration selects the register by `cfg_sel`:
  - 0 is the unlock key;
  - 1 is the second key;
  - 2 is the block number;
  - 3 is the SRAM pointer;
  - 4 is the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Parameter register write strobe |
| cfg_sel | input | 3 | Parameter register select |
| cfg_wdata | input | 8 | Parameter write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 erase, 1 program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| key1_q | output | 8 | Unlock key / primary status |
| key2_q | output | 8 | Second key / cleared on failure |
| acc_q | output | 8 | Result register |
| prot_blk | output | $clog2(NUM_BLOCKS) | Block number sent to protection unit |
| prot_lvl | input | 2 | Protection level returned |
| sram_rd | output | 1 | SRAM read strobe (data next cycle) |
| sram_addr | output | 8 | SRAM read address |
| sram_rdata | input | 8 | SRAM read data |
| fl_erase | output | 1 | Erase pulse |
| fl_prog | output | 1 | Program pulse |
| fl_addr | output | $clog2(NUM_BLOCKS)+6 | Flash byte address |
| fl_wdata | output | 8 | Program data |

## Verification
The hardest situation to reach from the ports is a command or register write that arrives while an operation is running. The block must ignore it without corrupting the running operation or the parameters of the next one. A directed case starts a long erase with divider 56h and, midway, raises a program strobe and writes new values to the second key and the block number. A later command that reuses the block register shows whether the ignored write leaked through. Random commands mix bad keys, out-of-range blocks, locked levels and a pointer that wraps the SRAM. A bench model of the flash array then compares every byte after each command.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and encodings for the flash sequencer.
// Assumes: byte-wide parameter registers; op and select codes fixed as below.
package flash_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ERASE,
        ST_FETCH,
        ST_LATCH,
        ST_PROG
    } seq_state_t;

    localparam logic [2:0] SEL_KEY1  = 3'd0;
    localparam logic [2:0] SEL_KEY2  = 3'd1;
    localparam logic [2:0] SEL_BLK   = 3'd2;
    localparam logic [2:0] SEL_PTR   = 3'd3;
    localparam logic [2:0] SEL_DIV   = 3'd4;

    localparam logic OP_ERASE = 1'b0;
    localparam logic OP_WRITE = 1'b1;

    localparam logic [7:0] CODE_FAIL = 8'h01;
    localparam logic [7:0] CODE_PASS = 8'h00;
endpackage

// File: rtl/flash_seq_regs.sv
`timescale 1ns/1ps
// Parameter and status register file.
// Host writes land only while idle; the controller overwrites the key and
// result registers with the pass/fail encoding at the end of each command.
module flash_seq_regs
    import flash_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic       cfg_we,
    input  logic [2:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic       st_we,
    input  logic       st_pass,
    output logic [7:0] key1,
    output logic [7:0] key2,
    output logic [7:0] blk,
    output logic [7:0] ptr,
    output logic [7:0] div,
    output logic [7:0] acc
);
    logic host_wr;
    assign host_wr = cfg_we && !busy;

    // Host parameter writes and end-of-command status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key1 <= '0;
            key2 <= '0;
            blk  <= '0;
            ptr  <= '0;
            div  <= '0;
            acc  <= '0;
        end else if (st_we) begin
            if (st_pass) begin
                key1 <= CODE_PASS;
                acc  <= blk;
            end else begin
                key1 <= CODE_FAIL;
                key2 <= '0;
                acc  <= '0;
            end
        end else if (host_wr) begin
            case (cfg_sel)
                SEL_KEY1: key1 <= cfg_wdata;
                SEL_KEY2: key2 <= cfg_wdata;
                SEL_BLK:  blk  <= cfg_wdata;
                SEL_PTR:  ptr  <= cfg_wdata;
                SEL_DIV:  div  <= cfg_wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/flash_seq_gate.sv
`timescale 1ns/1ps
// Admission check: unlock key, block range and protection level.
// Purely combinational; evaluated by the controller in its checking cycle.
module flash_seq_gate #(
    parameter int         NUM_BLOCKS = 128,
    parameter logic [7:0] KEY_VALUE  = 8'h3A,
    parameter logic [1:0] LOCK_LEVEL = 2'b11
) (
    input  logic [7:0] key1,
    input  logic [7:0] blk,
    input  logic [1:0] prot_lvl,
    output logic       ok
);
    logic key_ok, range_ok, prot_ok;

    // Combine the three independent admission conditions.
    always_comb begin
        key_ok   = (key1 == KEY_VALUE);
        range_ok = (32'(blk) < NUM_BLOCKS);
        prot_ok  = (prot_lvl != LOCK_LEVEL);
        ok       = key_ok && range_ok && prot_ok;
    end
endmodule

// File: rtl/flash_seq_timer.sv
`timescale 1ns/1ps
// Pulse-length down-counter. A load sets it so that the pulse lasts
// max(load_val,1) cycles; 'last' marks the final cycle of the pulse.
module flash_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Load on pulse entry, count down while the pulse runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/flash_seq_ctrl.sv
`timescale 1ns/1ps
// Command state machine: accept, check, then either one erase pulse or a
// fetch/latch/program loop over every byte of the block.
// Assumes SRAM returns read data one cycle after sram_rd.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int BLOCK_BYTES = 64,
    parameter int OFF_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic             ok,
    input  logic             tmr_last,
    input  logic [7:0]       ptr,
    input  logic [7:0]       sram_rdata,
    output logic             busy,
    output logic             done,
    output logic             st_we,
    output logic             st_pass,
    output logic             tmr_load,
    output logic             tmr_run,
    output logic             sram_rd,
    output logic [7:0]       sram_addr,
    output logic             fl_erase,
    output logic             fl_prog,
    output logic [OFF_W-1:0] fl_off,
    output logic [7:0]       fl_wdata
);
    localparam logic [OFF_W-1:0] IDX_LAST = OFF_W'(BLOCK_BYTES - 1);

    seq_state_t       state;
    logic             op_q;
    logic [OFF_W-1:0] idx;
    logic [7:0]       dbuf;
    logic             last_byte;

    assign last_byte = (idx == IDX_LAST);

    // Sequence through the command phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op_q  <= OP_ERASE;
            idx   <= '0;
            dbuf  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q  <= cmd_op;
                        idx   <= '0;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!ok) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else if (op_q == OP_ERASE) begin
                        state <= ST_ERASE;
                    end else begin
                        state <= ST_FETCH;
                    end
                end
                ST_ERASE: begin
                    if (tmr_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_FETCH: state <= ST_LATCH;
                ST_LATCH: begin
                    dbuf  <= sram_rdata;
                    state <= ST_PROG;
                end
                ST_PROG: begin
                    if (tmr_last) begin
                        if (last_byte) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode strobes, timer control and status write from the phase.
    always_comb begin
        busy     = (state != ST_IDLE);
        fl_erase = (state == ST_ERASE);
        fl_prog  = (state == ST_PROG);
        sram_rd  = (state == ST_FETCH);
        tmr_run  = fl_erase || fl_prog;
        tmr_load = (state == ST_LATCH) ||
                   (state == ST_CHECK && ok && op_q == OP_ERASE);
        st_we    = (state == ST_CHECK && !ok) ||
                   (state == ST_ERASE && tmr_last) ||
                   (state == ST_PROG && tmr_last && last_byte);
        st_pass  = (state != ST_CHECK);
        fl_off   = idx;
        fl_wdata = dbuf;
        sram_addr = ptr + {{(8 - OFF_W){1'b0}}, idx};
    end
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
// Top of the flash block erase/program sequencer.
// Assumes an external protection unit answers prot_lvl combinationally for
// prot_blk, and the flash array reacts to fl_erase / fl_prog pulses.
module flash_seq #(
    parameter int         NUM_BLOCKS  = 128,
    parameter int         BLOCK_BYTES = 64,
    parameter logic [7:0] KEY_VALUE   = 8'h3A,
    parameter logic [1:0] LOCK_LEVEL  = 2'b11,
    localparam int        BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int        OFF_W       = $clog2(BLOCK_BYTES),
    localparam int        ADDR_W      = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              cmd_valid,
    input  logic              cmd_op,
    output logic              busy,
    output logic              done,
    output logic [7:0]        key1_q,
    output logic [7:0]        key2_q,
    output logic [7:0]        acc_q,
    output logic [BLK_W-1:0]  prot_blk,
    input  logic [1:0]        prot_lvl,
    output logic              sram_rd,
    output logic [7:0]        sram_addr,
    input  logic [7:0]        sram_rdata,
    output logic              fl_erase,
    output logic              fl_prog,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata
);
    logic [7:0]       blk, ptr, div;
    logic             ok, tmr_last, tmr_load, tmr_run, st_we, st_pass;
    logic [OFF_W-1:0] fl_off;

    flash_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .st_we     (st_we),
        .st_pass   (st_pass),
        .key1      (key1_q),
        .key2      (key2_q),
        .blk       (blk),
        .ptr       (ptr),
        .div       (div),
        .acc       (acc_q)
    );

    flash_seq_gate #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .KEY_VALUE  (KEY_VALUE),
        .LOCK_LEVEL (LOCK_LEVEL)
    ) u_gate (
        .key1     (key1_q),
        .blk      (blk),
        .prot_lvl (prot_lvl),
        .ok       (ok)
    );

    flash_seq_timer #(.CNT_W(8)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .run      (tmr_run),
        .load_val (div),
        .last     (tmr_last)
    );

    flash_seq_ctrl #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .OFF_W       (OFF_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .ok         (ok),
        .tmr_last   (tmr_last),
        .ptr        (ptr),
        .sram_rdata (sram_rdata),
        .busy       (busy),
        .done       (done),
        .st_we      (st_we),
        .st_pass    (st_pass),
        .tmr_load   (tmr_load),
        .tmr_run    (tmr_run),
        .sram_rd    (sram_rd),
        .sram_addr  (sram_addr),
        .fl_erase   (fl_erase),
        .fl_prog    (fl_prog),
        .fl_off     (fl_off),
        .fl_wdata   (fl_wdata)
    );

    assign prot_blk = blk[BLK_W-1:0];
    assign fl_addr  = {blk[BLK_W-1:0], fl_off};
endmodule

// File: rtl/flash_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for flash_seq, attached by bind below.
module flash_seq_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              sram_rd,
    input logic              fl_erase,
    input logic              fl_prog,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_wdata,
    input logic [7:0]        key1_q,
    input logic [7:0]        key2_q,
    input logic [7:0]        acc_q
);
    // R7: erase and program pulses never overlap.
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_erase && fl_prog));

    // R9: no flash or SRAM activity outside an operation.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fl_erase && !fl_prog && !sram_rd));

    // R9: done follows the end of busy.
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: address and data steady through a program pulse.
    a_r8_pulse_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog && $past(fl_prog)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

    // R5: failure code clears the second key and the result.
    a_r5_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && key1_q == 8'h01) |-> (key2_q == 8'h00 && acc_q == 8'h00));
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .sram_rd  (sram_rd),
    .fl_erase (fl_erase),
    .fl_prog  (fl_prog),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .key1_q   (key1_q),
    .key2_q   (key2_q),
    .acc_q    (acc_q)
);

// File: tb/tb_flash_seq.sv
`timescale 1ns/1ps
module tb_flash_seq;
    localparam int NB = 32;
    localparam int BW = 5;
    localparam int AW = 11;
    localparam int NBYTES = NB * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          cmd_valid = 1'b0;
    logic          cmd_op = 1'b0;
    logic          busy, done, sram_rd, fl_erase, fl_prog;
    logic [7:0]    key1_q, key2_q, acc_q, sram_addr, fl_wdata;
    logic [7:0]    sram_rdata = '0;
    logic [BW-1:0] prot_blk;
    logic [1:0]    prot_lvl;
    logic [AW-1:0] fl_addr;

    flash_seq #(.NUM_BLOCKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done), .key1_q(key1_q), .key2_q(key2_q),
        .acc_q(acc_q), .prot_blk(prot_blk), .prot_lvl(prot_lvl),
        .sram_rd(sram_rd), .sram_addr(sram_addr), .sram_rdata(sram_rdata),
        .fl_erase(fl_erase), .fl_prog(fl_prog), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata)
    );

    always #2.5 clk = ~clk;

    logic [7:0] fmem [NBYTES];
    logic [7:0] emem [NBYTES];
    logic [7:0] sram [256];
    logic [1:0] prot [NB];

    int checks = 0, failures = 0, cyc = 0;
    int mon_err = 0, n_er = 0, n_pg = 0, ew = 0, pw = 0, pidx = 0;
    int exp_w = 1, exp_base = 0;
    logic [7:0] cur_ptr = '0;
    logic [7:0] sh_key2 = '0, sh_blk = '0, sh_ptr = '0, sh_div = '0;

    assign prot_lvl = prot[prot_blk];

    // SRAM model: data one cycle after the read strobe.
    always @(posedge clk) if (sram_rd) sram_rdata <= sram[sram_addr];

    // Flash array model and pulse monitor.
    always @(posedge clk) begin
        if (fl_erase) begin
            if (ew == 0) begin
                n_er = n_er + 1;
                if (int'(fl_addr) != exp_base) mon_err = mon_err + 1;
                for (int i = 0; i < 64; i++) fmem[{fl_addr[AW-1:6], 6'(i)}] = 8'hFF;
            end
            ew = ew + 1;
        end else if (ew != 0) begin
            if (ew != exp_w) mon_err = mon_err + 1;
            ew = 0;
        end
        if (fl_prog) begin
            if (pw == 0) begin
                n_pg = n_pg + 1;
                if (int'(fl_addr) != exp_base + pidx) mon_err = mon_err + 1;
                if (fl_wdata != sram[8'(cur_ptr + 8'(pidx))]) mon_err = mon_err + 1;
                fmem[fl_addr] = fmem[fl_addr] & fl_wdata;
                pidx = pidx + 1;
            end
            pw = pw + 1;
        end else if (pw != 0) begin
            if (pw != exp_w) mon_err = mon_err + 1;
            pw = 0;
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run exceeded cycle limit act=%0d exp<=190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd1: sh_key2 = val;
            3'd2: sh_blk = val;
            3'd3: sh_ptr = val;
            3'd4: sh_div = val;
            default: ;
        endcase
    endtask

    // Issue one command, predict, and check status, timing and flash contents.
    task automatic run(input logic op, input logic [7:0] key1, input string why,
                       input bit disturb);
        bit pass;
        int w, bcnt, exp_busy, mism;
        cfg(3'd0, key1);
        pass = (key1 == 8'h3A) && (int'(sh_blk) < NB) && (prot[sh_blk[BW-1:0]] != 2'b11);
        w = (sh_div == 0) ? 1 : int'(sh_div);
        exp_w = w; exp_base = int'(sh_blk) * 64; cur_ptr = sh_ptr;
        mon_err = 0; n_er = 0; n_pg = 0; pidx = 0;
        if (pass) begin
            for (int k = 0; k < 64; k++) begin
                if (op == 1'b0) emem[exp_base + k] = 8'hFF;
                else emem[exp_base + k] = emem[exp_base + k] & sram[8'(sh_ptr + 8'(k))];
            end
        end
        exp_busy = !pass ? 1 : (op == 1'b0 ? 1 + w : 1 + 64 * (w + 2));
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcnt = 0;
        while (!done && bcnt < 20000) begin
            if (busy) bcnt = bcnt + 1;
            if (disturb && bcnt == 3) begin
                cmd_valid = 1'b1; cmd_op = 1'b1;
                cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 8'h99;
            end else if (disturb && bcnt == 4) begin
                cmd_valid = 1'b0;
                cfg_sel = 3'd2; cfg_wdata = 8'd7;
            end else if (disturb && bcnt == 5) begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
        end
        chk({"R9 busy length ", why}, bcnt, exp_busy);
        chk("R9 done low busy", int'(busy), 0);
        @(posedge clk);
        @(negedge clk);
        chk(pass ? "R6 key1 pass" : {"R5 key1 fail ", why}, key1_q, pass ? 0 : 1);
        chk(pass ? "R6 key2 kept" : "R5 key2 cleared", key2_q, pass ? sh_key2 : 0);
        chk(pass ? "R6 acc block" : "R5 acc cleared", acc_q, pass ? sh_blk : 0);
        chk({"R7 erase pulses ", why}, n_er, (pass && op == 1'b0) ? 1 : 0);
        chk({"R8 program pulses ", why}, n_pg, (pass && op == 1'b1) ? 64 : 0);
        chk("R8 pulse width/address/data", mon_err, 0);
        mism = 0;
        for (int a = 0; a < NBYTES; a++) if (fmem[a] != emem[a]) mism = mism + 1;
        chk({"R4 flash contents ", why}, mism, 0);
        if (!pass) sh_key2 = 8'h00;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < NBYTES; a++) begin fmem[a] = 8'hFF; emem[a] = 8'hFF; end
        for (int a = 0; a < 256; a++) sram[a] = 8'($urandom);
        for (int b = 0; b < NB; b++) prot[b] = 2'b00;
        prot[9] = 2'b11; prot[10] = 2'b10; prot[11] = 2'b01;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobes", {fl_erase, fl_prog, sram_rd}, 0);
        chk("R1 key1/key2/acc", {key1_q, key2_q, acc_q}, 0);

        // R11 register selects; R7 erase; R8 program with pointer wrap
        cfg(3'd1, 8'h5C); cfg(3'd2, 8'd3); cfg(3'd4, 8'd5);
        run(1'b0, 8'h3A, "R7", 1'b0);
        cfg(3'd1, 8'h21); cfg(3'd3, 8'hF0); cfg(3'd4, 8'd2);
        run(1'b1, 8'h3A, "R8 wrap", 1'b0);
        cfg(3'd4, 8'd0); cfg(3'd3, 8'h11);
        run(1'b1, 8'h3A, "R8 AND div0", 1'b0);
        // R2 wrong key
        cfg(3'd1, 8'h77);
        run(1'b1, 8'h3B, "R2", 1'b0);
        // R3 out of range
        cfg(3'd1, 8'h42); cfg(3'd2, 8'd32);
        run(1'b0, 8'h3A, "R3", 1'b0);
        cfg(3'd2, 8'hFF);
        run(1'b1, 8'h3A, "R3", 1'b0);
        // R4 locked block, then permitted levels
        cfg(3'd2, 8'd9); cfg(3'd4, 8'd1);
        run(1'b1, 8'h3A, "R4 locked", 1'b0);
        cfg(3'd2, 8'd10);
        run(1'b1, 8'h3A, "R4 level2", 1'b0);
        cfg(3'd2, 8'd11);
        run(1'b0, 8'h3A, "R4 level1", 1'b0);
        // R10 disturbance during a long erase with divider 56h
        cfg(3'd1, 8'h6D); cfg(3'd2, 8'd5); cfg(3'd4, 8'h56);
        run(1'b0, 8'h3A, "R10", 1'b1);
        cfg(3'd4, 8'd1);
        run(1'b0, 8'h3A, "R10 blk kept", 1'b0);
        chk("R10 block register unchanged", acc_q, 5);

        // Constrained random commands
        for (int n = 0; n < 40; n++) begin
            logic [7:0] k1;
            prot[$urandom_range(NB - 1)] = 2'($urandom);
            cfg(3'd1, 8'($urandom));
            cfg(3'd2, 8'($urandom_range(NB + 7)));
            cfg(3'd3, 8'($urandom));
            cfg(3'd4, 8'($urandom_range(7)));
            k1 = ($urandom_range(7) == 0) ? 8'($urandom) : 8'h3A;
            run(1'($urandom), k1, "random", 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule